// File: doc/BRIEF.md
# Write-Busy Status Read Responder

This block sits on the read path of a byte-wide non-volatile store. It decides what a read returns while the store is busy with a self-timed internal write. Outside that window a read returns the array data unchanged. Inside it, a read returns an in-band status word from which software can tell when the write has finished.

The status word offers two completion checks. One bit carries the inverted top bit of the byte most recently loaded, so it only matches the true data once the write is over. A second bit flips on every read made during the window. The remaining bits carry the loaded byte as it was loaded.

The write controller drives the busy flag and the loaded byte. The array supplies read data in the same cycle as the read strobe. The block registers one read result per strobe and has no other side effects.

Top module: `wbsr_responder`

## Requirements
- R1: While the status window is open, a read returns the inverse of bit 7 (CPL_BIT) of the last loaded byte on data bit 7.
- R2: During the status window, data bit 6 (TGL_BIT) flips between consecutive reads. The toggle state changes only on a read strobe taken during the window; clock cycles without a read leave it unchanged.
- R3: When the window is closed, a read returns all eight bits of the array data unchanged. This includes bit 6, which no longer toggles.
- R4: The toggle state restarts at 0 at the start of each write cycle, which is the first cycle with busy high after a cycle with busy low. The first read of the window returns 0 on bit 6, and this also holds when that read falls in the starting cycle itself.
- R5: During the window, data bits 5..0 return bits 5..0 of the last loaded byte.
- R6: The window closes one cycle after busy falls. A read in the cycle where busy is low but was high in the previous cycle still returns the status word.
- R7: Read data and its valid flag appear one clock after the strobe. Without a strobe, the valid flag is low and the data output holds its value. Reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Internal write cycle in progress |
| last_data | input | DATA_W | Byte most recently loaded for writing |
| rd_stb | input | 1 | Read request, one per cycle |
| arr_data | input | DATA_W | Array read data for the current read |
| rd_data | output | DATA_W | Registered read result |
| rd_valid | output | 1 | rd_data was updated by a read this cycle |

## Verification
The bench builds the block with its default widths and bit positions: an 8-bit bus, with the complement bit on 7 and the toggle bit on 6. These values make every status word a literal that can be written down from the requirements.

The stimulus includes several full busy windows:
- an odd number of reads, so the toggle is left at 1 and the restart at the next write is visible;
- an idle clock inside a window, which exposes a toggle that counts clocks instead of reads;
- reads placed exactly on busy rising and on busy falling.

A reset taken in the middle of a window is also covered.

// File: rtl/wbsr_pkg.sv
package wbsr_pkg;
  // Which source feeds the registered read result.
  typedef enum logic {
    SRC_ARRAY  = 1'b0,
    SRC_STATUS = 1'b1
  } rd_src_e;
endpackage

// File: rtl/wbsr_window.sv
module wbsr_window (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  output logic start_pulse,
  output logic busy_prev,
  output logic status_mode
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy;
  end

  assign busy_prev   = busy_q;
  assign start_pulse = busy & ~busy_q;
  // Window stays open one extra cycle so that a read landing on completion sees status.
  assign status_mode = busy | busy_q;

  AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> status_mode); // R4
endmodule

// File: rtl/wbsr_toggle.sv
module wbsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic start_pulse,
  input  logic advance,
  output logic tog_cur
);
  logic tog_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           tog_q <= 1'b0;
    else if (start_pulse) tog_q <= advance;   // restart at 0, then advance if read now
    else if (advance)     tog_q <= ~tog_q;
  end

  assign tog_cur = start_pulse ? 1'b0 : tog_q;

  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !start_pulse) |=> (tog_q != $past(tog_q))); // R2
  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !start_pulse) |=> $stable(tog_q)); // R2
endmodule

// File: rtl/wbsr_responder.sv
module wbsr_responder #(
  parameter int DATA_W  = 8,
  parameter int CPL_BIT = 7,
  parameter int TGL_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [DATA_W-1:0] last_data,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  import wbsr_pkg::*;

  localparam logic [DATA_W-1:0] FLAG_MASK = (DATA_W'(1) << CPL_BIT) | (DATA_W'(1) << TGL_BIT);
  localparam logic [DATA_W-1:0] PASS_MASK = ~FLAG_MASK;

  function automatic logic [DATA_W-1:0] poll_word(input logic [DATA_W-1:0] ld, input logic tg);
    logic [DATA_W-1:0] w;
    w          = ld;
    w[CPL_BIT] = ~ld[CPL_BIT];
    w[TGL_BIT] = tg;
    return w;
  endfunction

  logic    start_pulse, busy_prev, status_mode, tog_cur, poll_advance;
  rd_src_e rd_src;
  logic [DATA_W-1:0] next_word;

  wbsr_window u_window (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .start_pulse (start_pulse),
    .busy_prev   (busy_prev),
    .status_mode (status_mode)
  );

  assign poll_advance = rd_stb & status_mode;

  wbsr_toggle u_toggle (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (start_pulse),
    .advance     (poll_advance),
    .tog_cur     (tog_cur)
  );

  assign rd_src    = status_mode ? SRC_STATUS : SRC_ARRAY;
  assign next_word = (rd_src == SRC_STATUS) ? poll_word(last_data, tog_cur) : arr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= next_word;
    end
  end

  AST_CPL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(status_mode)) |-> (rd_data[CPL_BIT] == ~$past(last_data[CPL_BIT]))); // R1
  AST_TRUE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !$past(status_mode)) |-> (rd_data == $past(arr_data))); // R3
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(start_pulse)) |-> (rd_data[TGL_BIT] == 1'b0)); // R4
  AST_PASS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(status_mode)) |-> ((rd_data & PASS_MASK) == ($past(last_data) & PASS_MASK))); // R5
  AST_END_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !busy && busy_prev) |=> (rd_data[CPL_BIT] == ~$past(last_data[CPL_BIT]))); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ($stable(rd_data) && !rd_valid)); // R7
endmodule

// File: tb/wbsr_responder_tb_top.sv
module wbsr_responder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0;
  logic [7:0] last_data = '0;
  logic       rd_stb = 1'b0;
  logic [7:0] arr_data = '0;
  logic [7:0] rd_data;
  logic       rd_valid;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  wbsr_responder dut_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .last_data(last_data),
    .rd_stb(rd_stb), .arr_data(arr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // Row: {busy, rd, last_data, arr_data, expected, tag}; tag = requirement checked.
  typedef struct packed {
    logic       b;
    logic       rd;
    logic [7:0] ld;
    logic [7:0] arr;
    logic [7:0] exp;
    logic [7:0] tag;
  } vec_t;
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 8'h00, 8'hA5, 8'hA5, 8'd3},  // idle read: array data
    '{1'b1, 1'b1, 8'h3C, 8'hFF, 8'hBC, 8'd4},  // read on rising busy: bit6=0, bit7 inverted
    '{1'b1, 1'b1, 8'h3C, 8'hFF, 8'hFC, 8'd2},  // toggle flips
    '{1'b1, 1'b0, 8'h3C, 8'hFF, 8'h00, 8'd0},  // no read: toggle must not advance
    '{1'b1, 1'b1, 8'h3C, 8'hFF, 8'hBC, 8'd2},
    '{1'b1, 1'b1, 8'h3C, 8'hFF, 8'hFC, 8'd5},
    '{1'b0, 1'b1, 8'h3C, 8'h3C, 8'hBC, 8'd6},  // completion cycle still status
    '{1'b0, 1'b1, 8'h3C, 8'h3C, 8'h3C, 8'd3},
    '{1'b0, 1'b1, 8'h3C, 8'h7F, 8'h7F, 8'd3},
    '{1'b1, 1'b0, 8'h81, 8'h00, 8'h00, 8'd0},  // new write, toggle left at 1 must restart
    '{1'b1, 1'b1, 8'h81, 8'h00, 8'h01, 8'd4},
    '{1'b1, 1'b1, 8'h81, 8'h00, 8'h41, 8'd1},
    '{1'b0, 1'b0, 8'h81, 8'h00, 8'h00, 8'd0},
    '{1'b0, 1'b1, 8'h81, 8'hC3, 8'hC3, 8'd3},
    '{1'b1, 1'b1, 8'h40, 8'h00, 8'h80, 8'd1},
    '{1'b0, 1'b1, 8'h40, 8'h55, 8'hC0, 8'd6},
    '{1'b0, 1'b1, 8'h40, 8'h55, 8'h55, 8'd3}
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got valid/data %b/%h, expected %b/%h", req, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic       prev_rd;
    logic [7:0] prev_exp;
    logic [7:0] prev_tag;
    logic [7:0] held;
    prev_rd = 1'b0; prev_exp = '0; prev_tag = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 reset", {rd_valid, rd_data}, 9'h000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (prev_rd) check($sformatf("R%0d row", prev_tag), {rd_valid, rd_data}, {1'b1, prev_exp});
      busy = VEC[i].b; rd_stb = VEC[i].rd; last_data = VEC[i].ld; arr_data = VEC[i].arr;
      prev_rd = VEC[i].rd; prev_exp = VEC[i].exp; prev_tag = VEC[i].tag;
    end
    @(negedge clk);
    if (prev_rd) check($sformatf("R%0d row", prev_tag), {rd_valid, rd_data}, {1'b1, prev_exp});
    rd_stb = 1'b0; arr_data = 8'h99;
    held = rd_data;
    @(negedge clk);
    // R7: no strobe -> valid low, data held
    check("R7 hold", {rd_valid, rd_data}, {1'b0, held});

    // Directed: two reads inside one window give opposite bit 6 (R2), bit 7 inverted (R1)
    busy = 1'b1; last_data = 8'h2A; rd_stb = 1'b1;
    @(negedge clk);
    check("R1 first", {rd_valid, rd_data}, {1'b1, 8'hAA});
    @(negedge clk);
    check("R2 second", {rd_valid, rd_data}, {1'b1, 8'hEA});
    // Reset in the middle of a window, then idle read returns array (R3)
    rd_stb = 1'b0; rst_n = 1'b0; busy = 1'b0;
    @(negedge clk);
    check("R7 mid reset", {rd_valid, rd_data}, 9'h000);
    rst_n = 1'b1; arr_data = 8'h6E; rd_stb = 1'b1;
    @(negedge clk);
    check("R3 after reset", {rd_valid, rd_data}, {1'b1, 8'h6E});
    rd_stb = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule